// File: doc/BRIEF.md
# S/PDIF Input Sample-Rate Classifier

This block watches a biphase-mark coded serial audio line that is asynchronous to a fast reference clock. It does not decode the stream. It measures the shortest interval between two consecutive line transitions, in reference-clock cycles, and keeps that minimum over a programmable measurement window. When each window closes, it places the minimum on a ladder of per-rate thresholds and reports which of seven standard audio sample rates the line carries. It reports code 7 when no rate can be recognised.

The per-rate values come from two packed timer words and two packed threshold words that a register file drives. Each rate has a nominal timer, the reference count of one half-cell pulse, which is the reference frequency divided by 128 times the sample rate. Each threshold is the sum of two neighbouring timers. The block also shows the measured minimum width. It keeps a sticky interrupt-status byte whose mode-changed flag is cleared by writing a one to it. It sends a one-cycle interrupt pulse, gated by a mask, every time the reported mode changes.

Top module: `spdif_rate_clf`

## Requirements
- R1: After reset, `mode_o` is 7, `width_o` is 0, `irq_stat_o` is 0 and `irq_o` is 0.
- R2: Mode codes stand for rates as follows: 0 = 32 kHz, 1 = 44.1 kHz, 2 = 48 kHz, 3 = 88.2 kHz, 4 = 96 kHz, 5 = 176.4 kHz, 6 = 192 kHz, and 7 = no valid rate. For a valid width w, the reported mode is the lowest index i in 0..5 with 2*w > threshold(i). When no such index exists, the mode is 6.
- R3: Timer i is 8 bits wide. It sits in word `tmr_word0_i` for i < 4 and in `tmr_word1_i` otherwise, at bit offset 8*(3 - i mod 4), so that mode 0 occupies bits 31:24 of word 0. Threshold i (i = 0..5) is 10 bits wide. It sits in `thr_word0_i` for i < 3 and in `thr_word1_i` otherwise, at bit offset 10*(2 - i mod 3). Bits that no field uses are ignored.
- R4: The line passes through a two-flop synchroniser. Each interval between consecutive transitions is counted in reference cycles, and the interval that closes a window still counts for that window. At the close of a window, `width_o` shows the smallest complete interval in that window, saturating at 1023.
- R5: A window lasts `base_timer_i` reference cycles (a value of 0 acts as 1). The mode and width are re-evaluated only when a window closes.
- R6: A width w is valid only when 2*w >= timer(6) and w <= 2*timer(0). Outside that range the mode is 7 and `width_o` still shows w.
- R7: A window that contains no complete interval reports width 0 and mode 7.
- R8: While `width_sel_i` is 0, no interval is captured, so every window reports width 0 and mode 7.
- R9: `irq_stat_o` bit 2 is set in the cycle the reported mode changes, including moves between 7 and 0. A one on bit k of `irq_clr_i` clears status bit k. When a set and a clear of bit 2 fall in the same cycle, the set wins. The other status bits always read 0.
- R10: `irq_o` is high for exactly one cycle, in the cycle the mode changes, if `irq_mask_i` bit 2 is 1. It stays low when that mask bit is 0 or when a window confirms the same mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sdata_i | input | 1 | Asynchronous biphase-mark serial line |
| width_sel_i | input | 1 | 1 = measure minimum edge-to-edge width |
| base_timer_i | input | 20 | Window length in reference cycles |
| tmr_word0_i | input | 32 | Packed timers for modes 0..3 |
| tmr_word1_i | input | 32 | Packed timers for modes 4..6 |
| thr_word0_i | input | 32 | Packed thresholds for modes 0..2 |
| thr_word1_i | input | 32 | Packed thresholds for modes 3..5 |
| irq_mask_i | input | 8 | Interrupt enable per status bit |
| irq_clr_i | input | 8 | Write-one-to-clear strobe for status bits |
| mode_o | output | 3 | Detected rate code |
| width_o | output | 10 | Minimum width of last window, 0 = nothing captured |
| irq_stat_o | output | 8 | Sticky interrupt status, bit 2 = mode changed |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
Two events can land on the same edge: the mode register taking a new code, which sets status bit 2, and a software write-one clear of that bit. The bench holds the clear strobe for bit 2 high while the line switches from one rate to another, so the clear is certain to overlap the set. In the cycle the new mode code appears, the flag must read 1. In the following cycle, with no further change, it must read 0.

// File: rtl/spdif_clf_pkg.sv
package spdif_clf_pkg;

    localparam int NUM_MODES    = 7;
    localparam int MODE_W       = 3;
    localparam int TMR_W        = 8;
    localparam int THR_W        = 10;
    localparam int WID_W        = 10;
    localparam int BASE_W       = 20;
    localparam int WORD_W       = 32;
    localparam int IRQ_W        = 8;
    localparam int IRQ_MODE_BIT = 2;
    localparam int SYNC_STAGES  = 2;

    localparam logic [MODE_W-1:0] MODE_NONE = '1;

endpackage

// File: rtl/spdif_clf_sync.sv
module spdif_clf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_i,
    output logic edge_o
);

    localparam int SH_W = STAGES + 1;

    typedef struct packed {
        logic [SH_W-1:0] sh;
    } sync_st_t;

    sync_st_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.sh = {sync_q.sh[SH_W-2:0], din_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    // transition seen between the last synchronised sample and the one before
    assign edge_o = sync_q.sh[STAGES] ^ sync_q.sh[STAGES-1];

endmodule

// File: rtl/spdif_clf_meter.sv
module spdif_clf_meter #(
    parameter int BASE_W = 20,
    parameter int WID_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_i,
    input  logic              cap_en_i,
    input  logic [BASE_W-1:0] base_i,
    output logic              done_o,
    output logic [WID_W-1:0]  width_o
);

    localparam logic [WID_W-1:0] WID_MAX = '1;

    typedef struct packed {
        logic [BASE_W-1:0] win;
        logic [WID_W-1:0]  run;
        logic [WID_W-1:0]  minw;
        logic              have_prev;
        logic              done;
        logic [WID_W-1:0]  width;
    } meter_st_t;

    meter_st_t meter_d, meter_q;
    logic [WID_W-1:0] cand;
    logic [WID_W-1:0] cur_min;
    logic             take;
    logic             tick;

    always_comb begin
        meter_d      = meter_q;
        meter_d.done = 1'b0;

        tick = ({1'b0, meter_q.win} + (BASE_W+1)'(1)) >= {1'b0, base_i};
        cand = (meter_q.run == WID_MAX) ? WID_MAX : meter_q.run + 1'b1;
        take = edge_i & meter_q.have_prev & cap_en_i;
        cur_min = (take && (cand < meter_q.minw)) ? cand : meter_q.minw;

        if (edge_i) begin
            meter_d.run       = '0;
            meter_d.have_prev = 1'b1;
        end else if (meter_q.run != WID_MAX) begin
            meter_d.run = meter_q.run + 1'b1;
        end

        if (tick) begin
            meter_d.win   = '0;
            meter_d.done  = 1'b1;
            meter_d.width = (cur_min == WID_MAX) ? '0 : cur_min;
            meter_d.minw  = WID_MAX;
        end else begin
            meter_d.win  = meter_q.win + 1'b1;
            meter_d.minw = cur_min;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meter_q <= '{win: '0, run: '0, minw: WID_MAX, have_prev: 1'b0,
                         done: 1'b0, width: '0};
        end else begin
            meter_q <= meter_d;
        end
    end

    assign done_o  = meter_q.done;
    assign width_o = meter_q.width;

    // R8
    capture_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en_i && $past(!cap_en_i) && tick) |=> (width_o == '0));

endmodule

// File: rtl/spdif_clf_ladder.sv
module spdif_clf_ladder #(
    parameter int NUM_MODES = 7,
    parameter int MODE_W    = 3,
    parameter int TMR_W     = 8,
    parameter int THR_W     = 10,
    parameter int WID_W     = 10,
    parameter int WORD_W    = 32,
    parameter int TMR_WORDS = 2,
    parameter int THR_WORDS = 2
) (
    input  logic [TMR_WORDS-1:0][WORD_W-1:0] tmr_words_i,
    input  logic [THR_WORDS-1:0][WORD_W-1:0] thr_words_i,
    input  logic [WID_W-1:0]                 width_i,
    output logic [MODE_W-1:0]                mode_o
);

    localparam int TMR_PER  = WORD_W / TMR_W;
    localparam int THR_PER  = WORD_W / THR_W;
    localparam int NUM_THR  = NUM_MODES - 1;

    logic [TMR_W-1:0] tmr [NUM_MODES];
    logic [THR_W-1:0] thr [NUM_THR];
    logic [WID_W:0]   w2;
    logic             valid;
    logic             unused_bits;

    // lowest mode index in the most significant slot of each word
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_tmr
        localparam int WI = m / TMR_PER;
        localparam int SH = TMR_W * (TMR_PER - 1 - (m % TMR_PER));
        assign tmr[m] = tmr_words_i[WI][SH +: TMR_W];
    end

    for (genvar m = 0; m < NUM_THR; m++) begin : g_thr
        localparam int WI = m / THR_PER;
        localparam int SH = THR_W * (THR_PER - 1 - (m % THR_PER));
        assign thr[m] = thr_words_i[WI][SH +: THR_W];
    end

    assign unused_bits = ^{tmr_words_i, thr_words_i};

    always_comb begin
        w2    = {width_i, 1'b0};
        valid = (width_i != '0)
              && (w2 >= (WID_W+1)'(tmr[NUM_MODES-1]))
              && ({1'b0, width_i} <= (WID_W+1)'({tmr[0], 1'b0}));
        mode_o = MODE_W'(NUM_MODES - 1);
        for (int i = NUM_THR - 1; i >= 0; i--) begin
            if (w2 > (WID_W+1)'(thr[i])) mode_o = MODE_W'(i);
        end
        if (!valid) mode_o = '1;
    end

endmodule

// File: rtl/spdif_rate_clf.sv
module spdif_rate_clf
    import spdif_clf_pkg::*;
#(
    parameter int P_BASE_W = BASE_W,
    parameter int P_WID_W  = WID_W,
    parameter int P_MODE_W = MODE_W,
    parameter int P_IRQ_W  = IRQ_W,
    parameter int P_WORD_W = WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sdata_i,
    input  logic                width_sel_i,
    input  logic [P_BASE_W-1:0] base_timer_i,
    input  logic [P_WORD_W-1:0] tmr_word0_i,
    input  logic [P_WORD_W-1:0] tmr_word1_i,
    input  logic [P_WORD_W-1:0] thr_word0_i,
    input  logic [P_WORD_W-1:0] thr_word1_i,
    input  logic [P_IRQ_W-1:0]  irq_mask_i,
    input  logic [P_IRQ_W-1:0]  irq_clr_i,
    output logic [P_MODE_W-1:0] mode_o,
    output logic [P_WID_W-1:0]  width_o,
    output logic [P_IRQ_W-1:0]  irq_stat_o,
    output logic                irq_o
);

    localparam int TMR_WORDS = (NUM_MODES + (P_WORD_W / TMR_W) - 1) / (P_WORD_W / TMR_W);
    localparam int THR_WORDS = (NUM_MODES - 1 + (P_WORD_W / THR_W) - 1) / (P_WORD_W / THR_W);

    typedef struct packed {
        logic [P_MODE_W-1:0] mode;
        logic [P_IRQ_W-1:0]  stat;
        logic                irq;
    } top_st_t;

    top_st_t top_d, top_q;

    logic                               edge_s;
    logic                               win_done;
    logic [P_WID_W-1:0]                 meas_w;
    logic [P_MODE_W-1:0]                lad_mode;
    logic [TMR_WORDS-1:0][P_WORD_W-1:0] tmr_words;
    logic [THR_WORDS-1:0][P_WORD_W-1:0] thr_words;
    logic [P_IRQ_W-1:0]                 set_vec;

    assign tmr_words = {tmr_word1_i, tmr_word0_i};
    assign thr_words = {thr_word1_i, thr_word0_i};

    spdif_clf_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (sdata_i),
        .edge_o (edge_s)
    );

    spdif_clf_meter #(.BASE_W(P_BASE_W), .WID_W(P_WID_W)) meter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_i   (edge_s),
        .cap_en_i (width_sel_i),
        .base_i   (base_timer_i),
        .done_o   (win_done),
        .width_o  (meas_w)
    );

    spdif_clf_ladder #(
        .NUM_MODES (NUM_MODES),
        .MODE_W    (P_MODE_W),
        .TMR_W     (TMR_W),
        .THR_W     (THR_W),
        .WID_W     (P_WID_W),
        .WORD_W    (P_WORD_W),
        .TMR_WORDS (TMR_WORDS),
        .THR_WORDS (THR_WORDS)
    ) ladder_i (
        .tmr_words_i (tmr_words),
        .thr_words_i (thr_words),
        .width_i     (meas_w),
        .mode_o      (lad_mode)
    );

    always_comb begin
        top_d     = top_q;
        top_d.irq = 1'b0;
        set_vec   = '0;
        if (win_done && (lad_mode != top_q.mode)) begin
            top_d.mode            = lad_mode;
            set_vec[IRQ_MODE_BIT] = 1'b1;
        end
        // a fresh set outranks a clear in the same cycle
        top_d.stat = (top_q.stat & ~irq_clr_i) | set_vec;
        top_d.irq  = |(set_vec & irq_mask_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '{mode: MODE_NONE, stat: '0, irq: 1'b0};
        else        top_q <= top_d;
    end

    assign mode_o     = top_q.mode;
    assign width_o    = meas_w;
    assign irq_stat_o = top_q.stat;
    assign irq_o      = top_q.irq;

    // R9
    mode_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_q.mode != $past(top_q.mode)) |-> top_q.stat[IRQ_MODE_BIT]);

    // R5
    mode_at_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_q.mode != $past(top_q.mode)) |-> $past(win_done));

    // R7
    empty_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && (meas_w == '0)) |=> (top_q.mode == MODE_NONE));

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (top_q.stat[IRQ_MODE_BIT] && $past(irq_mask_i[IRQ_MODE_BIT])));

    // R10
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

endmodule

// File: tb/spdif_rate_clf_tb_top.sv
module spdif_rate_clf_tb_top;

    localparam int WIN  = 300;
    localparam int REFF = 400000000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdata = 1'b0;
    logic        width_sel = 1'b1;
    logic [19:0] base_timer = 20'(WIN);
    logic [31:0] tmr_w0, tmr_w1, thr_w0, thr_w1;
    logic [7:0]  irq_mask = 8'h04;
    logic [7:0]  irq_clr = 8'h00;
    logic [2:0]  mode_o;
    logic [9:0]  width_o;
    logic [7:0]  irq_stat_o;
    logic        irq_o;

    int rates [7] = '{32000, 44100, 48000, 88200, 96000, 176400, 192000};
    int tm [7];
    int th [6];
    int vectors = 0;
    int fails = 0;
    int irq_pulses = 0;
    int irq_double = 0;
    logic prev_irq = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    spdif_rate_clf dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sdata_i      (sdata),
        .width_sel_i  (width_sel),
        .base_timer_i (base_timer),
        .tmr_word0_i  (tmr_w0),
        .tmr_word1_i  (tmr_w1),
        .thr_word0_i  (thr_w0),
        .thr_word1_i  (thr_w1),
        .irq_mask_i   (irq_mask),
        .irq_clr_i    (irq_clr),
        .mode_o       (mode_o),
        .width_o      (width_o),
        .irq_stat_o   (irq_stat_o),
        .irq_o        (irq_o)
    );

    always @(negedge clk) begin
        if (irq_o) irq_pulses++;
        if (irq_o && prev_irq) irq_double++;
        prev_irq = irq_o;
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // toggles the line every p cycles; p == 0 holds it
    task automatic run_period(input int p, input int ncyc);
        int cnt = 0;
        for (int c = 0; c < ncyc; c++) begin
            @(posedge clk);
            #1;
            if (p != 0) begin
                cnt++;
                if (cnt >= p) begin
                    sdata = ~sdata;
                    cnt = 0;
                end
            end
        end
    endtask

    task automatic pulse_clr();
        @(posedge clk); #1 irq_clr = 8'hFF;
        @(posedge clk); #1 irq_clr = 8'h00;
    endtask

    function automatic int exp_mode(input int p);
        int m;
        if (p == 0 || 2 * p < tm[6] || p > 2 * tm[0]) return 7;
        m = 6;
        for (int i = 5; i >= 0; i--) if (2 * p > th[i]) m = i;
        return m;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        int extra [7] = '{120, 150, 193, 194, 195, 196, 250};
        int prev_exp;
        int em;
        int p0;
        int changes;
        bit after;
        logic [2:0] pm;

        for (int i = 0; i < 7; i++) tm[i] = REFF / (128 * rates[i]);
        for (int i = 0; i < 6; i++) th[i] = tm[i] + tm[i+1];
        // R3: lowest mode in the top slot of each packed word
        tmr_w0 = {8'(tm[0]), 8'(tm[1]), 8'(tm[2]), 8'(tm[3])};
        tmr_w1 = {8'(tm[4]), 8'(tm[5]), 8'(tm[6]), 8'hA5};
        thr_w0 = {2'b11, 10'(th[0]), 10'(th[1]), 10'(th[2])};
        thr_w1 = {2'b10, 10'(th[3]), 10'(th[4]), 10'(th[5])};

        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 mode", int'(mode_o), 7);
        check("R1 width", int'(width_o), 0);
        check("R1 stat", int'(irq_stat_o), 0);
        check("R1 irq", int'(irq_o), 0);

        // R2 R3 R4 R6 R9 sweep of pulse widths
        prev_exp = 7;
        for (int k = 0; k < 107; k++) begin
            p0 = (k < 100) ? k + 1 : extra[k-100];
            run_period(p0, 3 * WIN);
            @(negedge clk);
            em = exp_mode(p0);
            check($sformatf("R4 width p=%0d", p0), int'(width_o), p0);
            check($sformatf("R2/R3/R6 mode p=%0d", p0), int'(mode_o), em);
            if (em != prev_exp) begin
                check($sformatf("R9 flag on change p=%0d", p0), int'(irq_stat_o[2]), 1);
                pulse_clr();
                @(negedge clk);
                check("R9 cleared", int'(irq_stat_o[2]), 0);
            end
            check("R9 other bits zero", int'(irq_stat_o & 8'hFB), 0);
            prev_exp = em;
        end

        // R7: no transitions at all
        run_period(0, 3 * WIN);
        @(negedge clk);
        check("R7 width", int'(width_o), 0);
        check("R7 mode", int'(mode_o), 7);

        // R8: capture disabled
        width_sel = 1'b0;
        run_period(40, 3 * WIN);
        @(negedge clk);
        check("R8 width", int'(width_o), 0);
        check("R8 mode", int'(mode_o), 7);
        width_sel = 1'b1;

        // R10: masked change, then unmasked change, then steady
        run_period(97, 3 * WIN);
        pulse_clr();
        irq_mask = 8'h00;
        p0 = irq_pulses;
        run_period(16, 3 * WIN);
        @(negedge clk);
        check("R10 masked mode", int'(mode_o), 6);
        check("R10 masked pulses", irq_pulses - p0, 0);
        check("R10 masked flag", int'(irq_stat_o[2]), 1);
        irq_mask = 8'h04;
        pulse_clr();
        p0 = irq_pulses;
        run_period(97, 3 * WIN);
        @(negedge clk);
        check("R10 unmasked pulse", int'(irq_pulses > p0), 1);
        pulse_clr();
        p0 = irq_pulses;
        run_period(97, 3 * WIN);
        @(negedge clk);
        check("R10 steady pulses", irq_pulses - p0, 0);
        check("R10 steady flag", int'(irq_stat_o[2]), 0);

        // R5: very long window keeps the old mode
        base_timer = 20'd60000;
        run_period(16, 3 * WIN);
        @(negedge clk);
        check("R5 held mode", int'(mode_o), 0);
        base_timer = 20'(WIN);
        run_period(16, 3 * WIN);
        @(negedge clk);
        check("R5 updated mode", int'(mode_o), 6);

        // R9: clear held while the mode changes, set must win
        run_period(97, 3 * WIN);
        pulse_clr();
        irq_clr = 8'h04;
        changes = 0;
        after = 1'b0;
        @(negedge clk);
        pm = mode_o;
        begin
            int cnt = 0;
            for (int c = 0; c < 3 * WIN; c++) begin
                @(posedge clk);
                #1;
                cnt++;
                if (cnt >= 16) begin
                    sdata = ~sdata;
                    cnt = 0;
                end
                @(negedge clk);
                if (mode_o != pm) begin
                    changes++;
                    check("R9 set wins over clear", int'(irq_stat_o[2]), 1);
                    after = 1'b1;
                end else if (after) begin
                    check("R9 clear after set", int'(irq_stat_o[2]), 0);
                    after = 1'b0;
                end
                pm = mode_o;
            end
        end
        irq_clr = 8'h00;
        check("R9 change seen", int'(changes > 0), 1);
        check("R10 single-cycle pulses", irq_double, 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule